// File: doc/BRIEF.md
# Activatable Watchdog Reset Timer

This block is a watchdog for a small processor subsystem. Software sees one 8-bit control register on a simple write bus. The top bit is an activation flag, and the low seven bits are a down-counter. A fixed internal prescaler decrements the counter once every `PRESCALE` system clocks. Once software activates the watchdog, it can only be switched off by a system reset. Software keeps the system alive by rewriting the counter, with bit 6 set, before bit 6 falls.

When the active watchdog sees counter bit 6 drop from 1 to 0, it raises a reset pulse. It also raises the pulse when software writes a counter value with bit 6 clear. A configuration input can make a halt request fire the pulse as well, but only while the watchdog is active. The pulse lasts `PULSE_CYCLES` clocks. While it lasts, the block sits at its reset state and ignores its inputs. After it ends, the block behaves as it does after a system reset.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is low, `ctrl_q` reads 8'h7F (inactive, counter at all ones) and `wdg_rst` is low.
- R2: Writing a 1 to bit 7 activates the watchdog. A later write with bit 7 at 0 leaves it active. Only `rst_n` or a watchdog pulse clears it.
- R3: Without writes, the counter in `ctrl_q[6:0]` falls by one every `PRESCALE` clocks and wraps from 7'h00 to 7'h7F.
- R4: If the watchdog is active and a prescaler tick would take the counter from 7'h40 to 7'h3F, the pulse starts on that edge and the counter does not decrement.
- R5: A write loads `wr_data[6:0]` into the counter and restarts the prescaler. The next decrement then comes `PRESCALE` clocks after the write edge.
- R6: A write with `wr_data[6]` at 0 starts the pulse on the write edge if the watchdog is active after that write, whether it was already active or is being activated by `wr_data[7]`.
- R7: `wdg_rst` is high for exactly `PULSE_CYCLES` clocks, starting from the trigger edge. During the pulse `ctrl_q` reads 8'h7F and writes and halt requests are ignored. Afterwards the block acts as it does after R1.
- R8: While the watchdog is inactive, no counter value and no halt request raises `wdg_rst`.
- R9: While active, `halt_req` with `halt_rst_en` high starts the pulse on the next edge. With `halt_rst_en` low, `halt_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 activate, bits 6:0 counter |
| halt_req | input | 1 | Halt request from the processor |
| halt_rst_en | input | 1 | Option: halt request resets while active |
| ctrl_q | output | 8 | Control register contents {active, counter} |
| wdg_rst | output | 1 | Watchdog reset pulse, active high |

## Verification
The assertions assume that `rst_n` is applied at start-up, and that `wr_en` and `halt_req` are single-clock strobes sampled on the rising edge. They also assume a `PRESCALE` of at least 2, so that a tick and a write never share a meaning. The bench drives every strobe for exactly one clock from the falling edge. It uses a short prescaler and pulse so that timeouts, the counter wrap and pulse recovery all occur within a short run. Writes and halt requests are deliberately placed inside a running pulse, to exercise the ignore rule of R7.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int PRESCALE     = 12288,
  parameter int PULSE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       halt_req,
  input  logic       halt_rst_en,
  output logic [7:0] ctrl_q,
  output logic       wdg_rst
);

  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int LW = $clog2(PULSE_CYCLES + 1);
  localparam logic [6:0] CNT_INIT = 7'h7F;
  localparam logic [6:0] CNT_EDGE = 7'h40;

  logic          act;
  logic [6:0]    cnt;
  logic [PW-1:0] pre;
  logic [LW-1:0] pul;

  logic tick, busy, act_wr, bad_wr, halt_hit, expire, fire;

  assign tick     = (pre == PW'(PRESCALE - 1));
  assign busy     = (pul != '0);
  assign act_wr   = act | wr_data[7];
  assign bad_wr   = wr_en & act_wr & ~wr_data[6];
  assign halt_hit = halt_req & halt_rst_en & act;
  assign expire   = ~wr_en & tick & act & (cnt == CNT_EDGE);
  assign fire     = ~busy & (bad_wr | halt_hit | expire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= CNT_INIT;
      pre <= '0;
      pul <= '0;
    end else if (busy) begin
      pul <= pul - 1'b1;
    end else if (fire) begin
      pul <= LW'(PULSE_CYCLES);
      act <= 1'b0;
      cnt <= CNT_INIT;
      pre <= '0;
    end else if (wr_en) begin
      act <= act_wr;
      cnt <= wr_data[6:0];
      pre <= '0;
    end else if (tick) begin
      pre <= '0;
      cnt <= cnt - 7'd1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  assign ctrl_q  = {act, cnt};
  assign wdg_rst = busy;

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (ctrl_q == 8'h7F && !wdg_rst));

  a_r2_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] |=> (ctrl_q[7] || wdg_rst));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_rst && !wr_en) |=> (wdg_rst || ctrl_q[6:0] == $past(ctrl_q[6:0])
                              || ctrl_q[6:0] == $past(ctrl_q[6:0]) - 7'd1));

  a_r4_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_rst && !wr_en && tick && ctrl_q == 8'hC0) |=> wdg_rst);

  a_r6_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_rst && wr_en && (ctrl_q[7] || wr_data[7]) && !wr_data[6]) |=> wdg_rst);

  a_r7_pulse_state: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> ctrl_q == 8'h7F);

  a_r8_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_rst && !ctrl_q[7] && !(wr_en && wr_data[7])) |=> !wdg_rst);

  a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdg_rst && ctrl_q[7] && halt_req && halt_rst_en) |=> wdg_rst);

endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int P = 8;
  localparam int L = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, halt_req = 0, halt_rst_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_q;
  logic wdg_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  int m_act, m_cnt, m_pre, m_pul;

  wdog_timer #(.PRESCALE(P), .PULSE_CYCLES(L)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .halt_req(halt_req), .halt_rst_en(halt_rst_en),
    .ctrl_q(ctrl_q), .wdg_rst(wdg_rst));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 127; m_pre = 0; m_pul = 0;
    end else if (m_pul > 0) begin
      m_pul = m_pul - 1;
    end else begin
      int na;
      bit trig;
      na = (m_act != 0 || wr_data[7]) ? 1 : 0;
      trig = 0;
      if (wr_en && na == 1 && !wr_data[6]) trig = 1;
      if (halt_req && halt_rst_en && m_act == 1) trig = 1;
      if (!wr_en && m_pre == P - 1 && m_act == 1 && m_cnt == 64) trig = 1;
      if (trig) begin
        m_pul = L; m_act = 0; m_cnt = 127; m_pre = 0;
      end else if (wr_en) begin
        m_act = na; m_cnt = wr_data & 8'h7F; m_pre = 0;
      end else if (m_pre == P - 1) begin
        m_pre = 0; m_cnt = (m_cnt + 127) % 128;
      end else begin
        m_pre = m_pre + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(ctrl_q == 8'((m_act << 7) | m_cnt), "R3 model register", ctrl_q, (m_act << 7) | m_cnt);
    chk(wdg_rst == (m_pul > 0), "R7 model pulse", wdg_rst, m_pul > 0);
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic halt_pulse;
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk(ctrl_q == 8'h7F, "R1 reset value", ctrl_q, 8'h7F);
    chk(wdg_rst == 0, "R1 reset pulse low", wdg_rst, 0);
    rst_n = 1;
    idle(1);

    // R3 free decrement and wrap, inactive
    wr(8'h00);
    idle(P - 1);
    chk(ctrl_q == 8'h00, "R3 hold before tick", ctrl_q, 8'h00);
    idle(1);
    chk(ctrl_q == 8'h7F, "R3 wrap", ctrl_q, 8'h7F);

    // R8 inactive crossing of bit 6
    wr(8'h40);
    idle(P);
    chk(ctrl_q == 8'h3F && !wdg_rst, "R8 inactive fall", ctrl_q, 8'h3F);
    halt_rst_en = 1;
    halt_pulse;
    chk(!wdg_rst, "R8 inactive halt", wdg_rst, 0);

    // R5 prescaler restart
    wr(8'h45);
    idle(P - 2);
    wr(8'h45);
    idle(P - 1);
    chk(ctrl_q == 8'h45, "R5 restart", ctrl_q, 8'h45);
    idle(1);
    chk(ctrl_q == 8'h44, "R5 first tick", ctrl_q, 8'h44);

    // R2 activation sticky
    wr(8'hFF);
    chk(ctrl_q == 8'hFF, "R2 activate", ctrl_q, 8'hFF);
    wr(8'h7F);
    chk(ctrl_q == 8'hFF, "R2 sticky", ctrl_q, 8'hFF);

    // R9 halt with option off
    halt_rst_en = 0;
    halt_pulse;
    chk(!wdg_rst, "R9 halt option off", wdg_rst, 0);

    // R4 timeout and R7 pulse
    wr(8'hC1);
    idle(2 * P - 1);
    chk(ctrl_q == 8'hC0 && !wdg_rst, "R4 before timeout", ctrl_q, 8'hC0);
    idle(1);
    chk(wdg_rst == 1, "R4 timeout pulse", wdg_rst, 1);
    chk(ctrl_q == 8'h7F, "R7 pulse register", ctrl_q, 8'h7F);
    wr(8'hFF);
    idle(L - 2);
    chk(wdg_rst == 0 && ctrl_q == 8'h7F, "R7 pulse length and writes ignored", ctrl_q, 8'h7F);

    // R6 activation write with bit 6 clear
    wr(8'hA0);
    chk(wdg_rst == 1, "R6 activating bad write", wdg_rst, 1);
    idle(L);
    wr(8'hD0);
    wr(8'h20);
    chk(wdg_rst == 1, "R6 active bad write", wdg_rst, 1);
    idle(L);

    // R9 halt while active
    wr(8'hFF);
    halt_rst_en = 1;
    halt_pulse;
    chk(wdg_rst == 1, "R9 halt reset", wdg_rst, 1);
    idle(L);
    chk(ctrl_q == 8'h7F && !wdg_rst, "R7 recovered", ctrl_q, 8'h7F);

    // refresh keeps it alive
    wr(8'hFF);
    for (int k = 0; k < 5; k++) begin
      idle(30 * P);
      chk(!wdg_rst, "R5 refresh", wdg_rst, 0);
      wr(8'h7F);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule